// File: doc/BRIEF.md
# Circular Line Buffer Vertical Scaler

This block sits between a pixel digitizer and an output raster generator. Each incoming scanline is written into a ring of line slots that holds a few dozen lines. The output side asks for lines at its own timing and reads them back. Each stored source line is shown on an integer number of consecutive output lines. Because only a handful of lines are held, the added delay is a few source lines rather than a frame. Taller output rasters need a deeper ring than a simple line doubler, because the visible part of the source frame is a smaller share of its total lines than the visible part of a tall output raster is of its own.

The replication factor sets the output height: 2 for 480 lines, 3 for 720, 4 or 5 for 1080 and 9 for 2160. A top margin of blank output lines gives letterboxing, for example at 4x on a 1080-line raster. A limit on the number of source lines shown crops the picture, for example 216 source lines at 5x. If the output side asks for a source line that has not yet been fully written, a per-line underflow flag is raised. The most recent complete line is then shown in its place.

Top module: `vscale_ring`

## Requirements
- R1: While reset is held and after it is released, before any read request, `out_valid` and `out_underflow` are 0 and `out_pix` is 0.
- R2: A pulse on `out_rd` produces `out_valid` high with the next pixel of the current output line on the following cycle. Pixels come back in the order they were written, and `out_pix` is 0 whenever `out_valid` is 0.
- R3: After `out_sof`, every picture line in the window repeats the current source line `cfg_rep` times before moving to the next one. A `cfg_rep` of 0 behaves as 1. Configuration is changed only together with `out_sof`.
- R4: The first `cfg_top` output lines after `out_sof` are black (all pixels 0) and do not consume source lines.
- R5: Once `cfg_show` source lines have been shown, every later output line of the frame is black. This crops the picture.
- R6: Source line k of a frame lives in ring slot k modulo `DEPTH`. It reads back correctly while fewer than `DEPTH` later lines of the same frame have been completed, so frames taller than the ring stream through it.
- R7: When a picture line requests a source line not yet completed in the current input frame, `out_underflow` is 1 for that whole output line and the most recent complete line is shown. If no line is complete yet, black is shown. The source position still advances normally.
- R8: `in_valid` is ignored on a cycle that carries `in_sof` or `in_sol`. Pixels beyond `LINE_PIX` in a line are ignored. A line restarted by `in_sol` before `LINE_PIX` pixels is rewritten into the same slot and does not count as complete.
- R9: Read requests past column `LINE_PIX-1` of a line return 0 with `out_valid` high.
- R10: `in_sof` restarts the input line count at source line 0. `out_sof` restarts the output side at source line 0 with a fresh top margin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rep | input | REP_W | Output lines per source line (0 acts as 1) |
| cfg_top | input | OL_W | Blank output lines before the picture |
| cfg_show | input | SL_W | Number of source lines displayed |
| in_sof | input | 1 | Start of input frame (also starts line 0) |
| in_sol | input | 1 | Start of a further input line |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | PIX_W | Input pixel value |
| out_sof | input | 1 | Start of output frame |
| out_sol | input | 1 | Start of output line |
| out_rd | input | 1 | Request next pixel of the output line |
| out_pix | output | PIX_W | Output pixel, 0 for black |
| out_valid | output | 1 | Output pixel valid, one cycle after out_rd |
| out_underflow | output | 1 | Current output line fell back to an earlier line |

## Verification
The bench goes after the counter edges where a wrong design would misplace whole lines. An off-by-one repeat counter shows each source line one time too many or too few. A margin that consumes source lines shifts the picture down. A missing crop leaks stale lines below the window. A frame of 30 lines through a 24-slot ring, read three lines behind the writer, catches a slot index that does not wrap or wraps at the wrong count; that error shows up as another line's pixels. The underflow cases separate falling back to the last complete line from showing the half-written one, or from showing black when data exists. Junk pixels on marker cycles, extra pixels past the line end and an aborted partial line would corrupt neighbouring slots if the write column were not bounded.

// File: rtl/vscale_pkg.sv
package vscale_pkg;

    // What an output line displays.
    typedef enum logic [1:0] {
        LK_BLACK    = 2'd0,
        LK_PIC      = 2'd1,
        LK_FALLBACK = 2'd2
    } line_kind_e;

endpackage

// File: rtl/vscale_line_ram.sv
module vscale_line_ram #(
    parameter int PIX_W  = 16,
    parameter int WORDS  = 768,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [PIX_W-1:0]  wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [PIX_W-1:0]  rdata
);

    logic [PIX_W-1:0] mem_q [WORDS];
    logic [PIX_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem_q[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/vscale_wr_ctrl.sv
module vscale_wr_ctrl #(
    parameter int PIX_W    = 16,
    parameter int LINE_PIX = 32,
    parameter int DEPTH    = 24,
    parameter int SL_W     = 9,
    parameter int SLOT_W   = 5,
    parameter int ADDR_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sof,
    input  logic              in_sol,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [PIX_W-1:0]  wdata,
    output logic [SL_W-1:0]   done_cnt,
    output logic [SLOT_W-1:0] last_slot
);

    localparam int COL_W = $clog2(LINE_PIX + 1);
    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(LINE_PIX - 1);
    localparam logic [COL_W-1:0]  COL_FULL  = COL_W'(LINE_PIX);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(DEPTH - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [COL_W-1:0]  col;
        logic [SL_W-1:0]   done;
        logic [SLOT_W-1:0] last;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic      we_d;

    always_comb begin
        st_d = st_q;
        we_d = 1'b0;
        if (in_sof) begin
            st_d.slot = '0;
            st_d.col  = '0;
            st_d.done = '0;
        end else if (in_sol) begin
            st_d.col = '0;
        end else if (in_valid && (st_q.col < COL_FULL)) begin
            we_d      = 1'b1;
            st_d.col  = st_q.col + COL_W'(1);
            if (st_q.col == COL_LAST) begin
                if (st_q.done != '1) begin
                    st_d.done = st_q.done + SL_W'(1);
                end
                st_d.last = st_q.slot;
                st_d.slot = (st_q.slot == SLOT_LAST) ? '0 : st_q.slot + SLOT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign we        = we_d;
    assign waddr     = ADDR_W'(st_q.slot) * ADDR_W'(LINE_PIX) + ADDR_W'(st_q.col);
    assign wdata     = in_pix;
    assign done_cnt  = st_q.done;
    assign last_slot = st_q.last;

    // R6: ring slot index stays inside the ring
    a_r6_slot_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot <= SLOT_LAST);

    // R8: completed-line count only steps by one outside a frame start
    a_r8_done_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sof |=> (done_cnt == $past(done_cnt)) || (done_cnt == $past(done_cnt) + SL_W'(1)));

    // R8: marker cycles never write the line store
    a_r8_marker_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sof || in_sol) |=> (st_q.col == '0));

endmodule

// File: rtl/vscale_rd_ctrl.sv
module vscale_rd_ctrl
    import vscale_pkg::*;
#(
    parameter int LINE_PIX = 32,
    parameter int DEPTH    = 24,
    parameter int SL_W     = 9,
    parameter int OL_W     = 12,
    parameter int REP_W    = 4,
    parameter int SLOT_W   = 5,
    parameter int ADDR_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REP_W-1:0]  cfg_rep,
    input  logic [OL_W-1:0]   cfg_top,
    input  logic [SL_W-1:0]   cfg_show,
    input  logic              out_sof,
    input  logic              out_sol,
    input  logic              out_rd,
    input  logic [SL_W-1:0]   wr_done,
    input  logic [SLOT_W-1:0] wr_last,
    output logic              re,
    output logic [ADDR_W-1:0] raddr,
    output logic              pix_vld,
    output logic              pix_blk,
    output logic              underflow
);

    localparam int COL_W = $clog2(LINE_PIX + 1);
    localparam logic [COL_W-1:0]  COL_FULL  = COL_W'(LINE_PIX);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(DEPTH - 1);

    typedef struct packed {
        logic [SL_W-1:0]   src;
        logic [SLOT_W-1:0] slot;
        logic [REP_W-1:0]  rep;
        logic [OL_W-1:0]   top_left;
        line_kind_e        kind;
        logic [SLOT_W-1:0] line_slot;
        logic [COL_W-1:0]  col;
        logic              under;
        logic              vld;
        logic              blk;
    } rd_state_t;

    rd_state_t        st_d, st_q;
    logic [REP_W-1:0] rep_eff;
    logic             re_d;

    assign rep_eff = (cfg_rep == '0) ? REP_W'(1) : cfg_rep;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        re_d     = 1'b0;
        if (out_sof) begin
            st_d.src      = '0;
            st_d.slot     = '0;
            st_d.rep      = '0;
            st_d.top_left = cfg_top;
            st_d.kind     = LK_BLACK;
            st_d.under    = 1'b0;
            st_d.col      = '0;
        end else if (out_sol) begin
            st_d.col   = '0;
            st_d.under = 1'b0;
            if (st_q.top_left != '0) begin
                st_d.top_left = st_q.top_left - OL_W'(1);
                st_d.kind     = LK_BLACK;
            end else if (st_q.src >= cfg_show) begin
                st_d.kind = LK_BLACK;
            end else begin
                if (st_q.src < wr_done) begin
                    st_d.kind      = LK_PIC;
                    st_d.line_slot = st_q.slot;
                end else begin
                    st_d.under = 1'b1;
                    if (wr_done != '0) begin
                        st_d.kind      = LK_FALLBACK;
                        st_d.line_slot = wr_last;
                    end else begin
                        st_d.kind = LK_BLACK;
                    end
                end
                if (st_q.rep == rep_eff - REP_W'(1)) begin
                    st_d.rep = '0;
                    if (st_q.src != '1) begin
                        st_d.src = st_q.src + SL_W'(1);
                    end
                    st_d.slot = (st_q.slot == SLOT_LAST) ? '0 : st_q.slot + SLOT_W'(1);
                end else begin
                    st_d.rep = st_q.rep + REP_W'(1);
                end
            end
        end else if (out_rd) begin
            st_d.vld = 1'b1;
            re_d     = (st_q.col < COL_FULL) && (st_q.kind != LK_BLACK);
            st_d.blk = !re_d;
            if (st_q.col < COL_FULL) begin
                st_d.col = st_q.col + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= LK_BLACK;
            st_q.blk  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign re        = re_d;
    assign raddr     = ADDR_W'(st_q.line_slot) * ADDR_W'(LINE_PIX) + ADDR_W'(st_q.col);
    assign pix_vld   = st_q.vld;
    assign pix_blk   = st_q.blk;
    assign underflow = st_q.under;

    // R3: repeat counter never reaches the replication factor
    a_r3_rep_below_factor: assert property (@(posedge clk) disable iff (!rst_n)
        !out_sof |-> (st_q.rep < rep_eff));

    // R5: source position never moves backwards within an output frame
    a_r5_src_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !out_sof |=> (st_q.src >= $past(st_q.src)));

    // R7: with complete lines available an underflow line is never black
    a_r7_fallback_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sol && !out_sof && (wr_done != '0)) |=> !(underflow && (st_q.kind == LK_BLACK)));

    // R6: read slot stays inside the ring
    a_r6_read_slot_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot <= SLOT_LAST);

endmodule

// File: rtl/vscale_ring.sv
module vscale_ring #(
    parameter int PIX_W    = 16,
    parameter int LINE_PIX = 32,
    parameter int DEPTH    = 24,
    parameter int SL_W     = 9,
    parameter int OL_W     = 12,
    parameter int REP_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REP_W-1:0] cfg_rep,
    input  logic [OL_W-1:0]  cfg_top,
    input  logic [SL_W-1:0]  cfg_show,
    input  logic             in_sof,
    input  logic             in_sol,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             out_sof,
    input  logic             out_sol,
    input  logic             out_rd,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_valid,
    output logic             out_underflow
);

    localparam int WORDS  = DEPTH * LINE_PIX;
    localparam int ADDR_W = $clog2(WORDS);
    localparam int SLOT_W = $clog2(DEPTH);

    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [PIX_W-1:0]  wdata;
    logic [SL_W-1:0]   done_cnt;
    logic [SLOT_W-1:0] last_slot;
    logic              re;
    logic [ADDR_W-1:0] raddr;
    logic [PIX_W-1:0]  rdata;
    logic              pix_vld;
    logic              pix_blk;
    logic              underflow;

    vscale_wr_ctrl #(
        .PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .DEPTH(DEPTH),
        .SL_W(SL_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)
    ) i_wr (
        .clk(clk), .rst_n(rst_n),
        .in_sof(in_sof), .in_sol(in_sol), .in_valid(in_valid), .in_pix(in_pix),
        .we(we), .waddr(waddr), .wdata(wdata),
        .done_cnt(done_cnt), .last_slot(last_slot)
    );

    vscale_line_ram #(
        .PIX_W(PIX_W), .WORDS(WORDS), .ADDR_W(ADDR_W)
    ) i_ram (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .re(re), .raddr(raddr), .rdata(rdata)
    );

    vscale_rd_ctrl #(
        .LINE_PIX(LINE_PIX), .DEPTH(DEPTH), .SL_W(SL_W), .OL_W(OL_W),
        .REP_W(REP_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)
    ) i_rd (
        .clk(clk), .rst_n(rst_n),
        .cfg_rep(cfg_rep), .cfg_top(cfg_top), .cfg_show(cfg_show),
        .out_sof(out_sof), .out_sol(out_sol), .out_rd(out_rd),
        .wr_done(done_cnt), .wr_last(last_slot),
        .re(re), .raddr(raddr),
        .pix_vld(pix_vld), .pix_blk(pix_blk), .underflow(underflow)
    );

    assign out_valid     = pix_vld;
    assign out_pix       = (pix_vld && !pix_blk) ? rdata : '0;
    assign out_underflow = underflow;

    // R2: each read request yields exactly one valid pixel a cycle later
    a_r2_valid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rd && !out_sol && !out_sof) |=> out_valid);

    a_r2_no_valid_without_rd: assert property (@(posedge clk) disable iff (!rst_n)
        !out_rd |=> !out_valid);

    // R2: no pixel data leaks while idle
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_pix == '0));

endmodule

// File: tb/test_vscale_ring.sv
module test_vscale_ring;

    localparam int CLK_PERIOD = 10;
    localparam int PIX_W      = 16;
    localparam int LINE_PIX   = 32;
    localparam int DEPTH      = 24;
    localparam int SL_W       = 9;
    localparam int OL_W       = 12;
    localparam int REP_W      = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [REP_W-1:0] cfg_rep = '0;
    logic [OL_W-1:0]  cfg_top = '0;
    logic [SL_W-1:0]  cfg_show = '0;
    logic             in_sof = 1'b0;
    logic             in_sol = 1'b0;
    logic             in_valid = 1'b0;
    logic [PIX_W-1:0] in_pix = '0;
    logic             out_sof = 1'b0;
    logic             out_sol = 1'b0;
    logic             out_rd = 1'b0;
    logic [PIX_W-1:0] out_pix;
    logic             out_valid;
    logic             out_underflow;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vscale_ring #(
        .PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .DEPTH(DEPTH),
        .SL_W(SL_W), .OL_W(OL_W), .REP_W(REP_W)
    ) i_vscale_ring (
        .clk(clk), .rst_n(rst_n),
        .cfg_rep(cfg_rep), .cfg_top(cfg_top), .cfg_show(cfg_show),
        .in_sof(in_sof), .in_sol(in_sol), .in_valid(in_valid), .in_pix(in_pix),
        .out_sof(out_sof), .out_sol(out_sol), .out_rd(out_rd),
        .out_pix(out_pix), .out_valid(out_valid), .out_underflow(out_underflow)
    );

    function automatic logic [PIX_W-1:0] pix(input int f, input int l, input int c);
        return PIX_W'(f * 4096 + l * 64 + c + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic in_line(input int f, input int l, input bit first);
        @(negedge clk);
        in_sof = first;
        in_sol = !first;
        in_valid = 1'b0;
        for (int c = 0; c < LINE_PIX; c++) begin
            @(negedge clk);
            in_sof = 1'b0;
            in_sol = 1'b0;
            in_valid = 1'b1;
            in_pix = pix(f, l, c);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic out_frame(input int rep, input int top, input int show);
        @(negedge clk);
        cfg_rep = REP_W'(rep);
        cfg_top = OL_W'(top);
        cfg_show = SL_W'(show);
        out_sof = 1'b1;
        @(negedge clk);
        out_sof = 1'b0;
    endtask

    // kind 0: black line, 1: pixels of line l of frame f
    task automatic out_line(input string req, input int kind, input int f, input int l,
                            input bit under, input int ncol);
        @(negedge clk);
        out_sol = 1'b1;
        @(negedge clk);
        out_sol = 1'b0;
        for (int c = 0; c <= ncol; c++) begin
            @(negedge clk);
            if (c > 0) begin
                logic [PIX_W-1:0] e;
                e = (kind == 0 || (c - 1) >= LINE_PIX) ? '0 : pix(f, l, c - 1);
                chk(out_valid && out_pix == e, req, int'(out_pix), int'(e));
                if (c == 1) begin
                    chk(out_underflow == under, {req, " underflow"}, int'(out_underflow), int'(under));
                end
            end
            out_rd = (c < ncol);
        end
        @(negedge clk);
        chk(!out_valid, {req, " R2 idle"}, int'(out_valid), 0);
    endtask

    task automatic t_reset;
        chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        chk(out_underflow == 1'b0, "R1 underflow", int'(out_underflow), 0);
        chk(out_pix == '0, "R1 pix", int'(out_pix), 0);
    endtask

    task automatic t_double;
        for (int l = 0; l < 4; l++) in_line(1, l, l == 0);
        out_frame(2, 0, 4);
        for (int o = 0; o < 8; o++) out_line("R3 R2 rep2", 1, 1, o / 2, 1'b0, LINE_PIX);
        out_line("R5 past window", 0, 0, 0, 1'b0, LINE_PIX);
    endtask

    task automatic t_letterbox_crop;
        out_frame(3, 2, 2);
        out_line("R4 top margin", 0, 0, 0, 1'b0, LINE_PIX);
        out_line("R4 top margin", 0, 0, 0, 1'b0, LINE_PIX);
        for (int o = 0; o < 6; o++) out_line("R3 rep3", 1, 1, o / 3, 1'b0, LINE_PIX);
        out_line("R5 crop", 0, 0, 0, 1'b0, LINE_PIX);
        out_line("R5 crop", 0, 0, 0, 1'b0, LINE_PIX);
    endtask

    task automatic t_rep_zero;
        out_frame(0, 0, 4);
        for (int o = 0; o < 3; o++) out_line("R3 R10 rep0", 1, 1, o, 1'b0, LINE_PIX);
    endtask

    task automatic t_underflow_data;
        in_line(2, 0, 1'b1);
        in_line(2, 1, 1'b0);
        out_frame(1, 0, 8);
        out_line("R7 R10 ok", 1, 2, 0, 1'b0, LINE_PIX);
        out_line("R7 ok", 1, 2, 1, 1'b0, LINE_PIX);
        out_line("R7 fallback", 1, 2, 1, 1'b1, LINE_PIX);
        in_line(2, 2, 1'b0);
        out_line("R7 fallback new", 1, 2, 2, 1'b1, LINE_PIX);
    endtask

    task automatic t_underflow_empty;
        @(negedge clk);
        in_sof = 1'b1;
        @(negedge clk);
        in_sof = 1'b0;
        out_frame(1, 0, 8);
        out_line("R7 R10 empty", 0, 0, 0, 1'b1, LINE_PIX);
        in_line(3, 0, 1'b0);
        out_line("R7 after first", 1, 3, 0, 1'b1, LINE_PIX);
    endtask

    task automatic t_ring_wrap;
        for (int l = 0; l < 3; l++) in_line(5, l, l == 0);
        out_frame(1, 0, 30);
        for (int l = 0; l < 30; l++) begin
            if (l + 3 < 30) in_line(5, l + 3, 1'b0);
            out_line("R6 ring", 1, 5, l, 1'b0, LINE_PIX);
        end
    endtask

    task automatic t_ignored_input;
        @(negedge clk);
        in_sof = 1'b1;
        in_valid = 1'b1;
        in_pix = 16'hDEAD;
        for (int c = 0; c < LINE_PIX; c++) begin
            @(negedge clk);
            in_sof = 1'b0;
            in_valid = 1'b1;
            in_pix = pix(7, 0, c);
        end
        @(negedge clk);
        in_sol = 1'b1;
        in_valid = 1'b0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            in_sol = 1'b0;
            in_valid = 1'b1;
            in_pix = 16'hBEEF;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_line(7, 1, 1'b0);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_pix = 16'hCAFE;
        end
        @(negedge clk);
        in_valid = 1'b0;
        out_frame(1, 0, 4);
        out_line("R8 marker pixel", 1, 7, 0, 1'b0, LINE_PIX);
        out_line("R8 aborted line", 1, 7, 1, 1'b0, LINE_PIX);
        out_line("R8 short line not complete", 1, 7, 1, 1'b1, LINE_PIX);
        in_line(7, 2, 1'b0);
        out_line("R8 extra pixels", 1, 7, 2, 1'b1, LINE_PIX);
    endtask

    task automatic t_past_end;
        out_frame(1, 0, 4);
        out_line("R9 past end", 1, 7, 0, 1'b0, LINE_PIX + 3);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_double();
        t_letterbox_crop();
        t_rep_zero();
        t_underflow_data();
        t_underflow_empty();
        t_ring_wrap();
        t_ignored_input();
        t_past_end();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

endmodule